// File: doc/BRIEF.md
# Indirect Scratch Register Port

This block lets software reach a small bank of 64-bit scratch registers through a pair of registers. Software first loads a selector (the address register), and then reads or writes the data register. Each data access is steered by the stored selector. The selector's group field decides what the access reaches. In the scratch window, a three-bit index picks one of eight scratch registers. One reserved group answers reads with a single status bit, which shows whether the core runs in wide (big-core) mode. Every other group is unimplemented.

The selector only takes values built from bits 9 to 3. A write that sets any other bit is refused, and the old selector stays in place. A refused selector write pulses the error output. So does any data access to an unimplemented location. Read data is registered, and it holds until the next read.

Top module: `isp_port`

## Requirements
- R1: A selector write (sel_data=0, wr_en=1) whose data has no bit set outside mask 0x3F8 is stored. A selector read (sel_data=0, rd_en=1) returns the stored value, zero-extended, on rdata one cycle later.
- R2: A selector write with any bit set outside 0x3F8 leaves the stored selector unchanged and pulses err.
- R3: The scratch index is selector bits [5:3]. With the default full window, a data access whose selector has bits [9:6] all zero (group values 0x000 and 0x020) reaches scratch register [index]. The eight registers hold their values independently.
- R4: A data read with group (selector AND 0x3E0) equal to 0x1E0 returns 0x8000_0000_0000_0000 when wide_mode is high at the strobe and zero when it is low. It does not raise err.
- R5: A data read with any group other than the scratch window and 0x1E0 returns zero and pulses err.
- R6: A data write outside the scratch window, including group 0x1E0, changes no scratch register and pulses err.
- R7: err is high for exactly one cycle, in the cycle after an offending strobe, and low otherwise.
- R8: Synchronous reset clears the selector, all scratch registers, rdata and err to zero.
- R9: rdata is updated only in the cycle after rd_en and holds between reads. A data read and a data write to the same scratch register in one cycle return the content from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_data | input | 1 | 0 selects the selector register, 1 selects the data register |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 64 | Write data |
| wide_mode | input | 1 | Core wide-mode status reported by group 0x1E0 |
| rdata | output | 64 | Registered read data |
| err | output | 1 | One-cycle pulse for a refused or unimplemented access |

## Verification
The stimulus first fills all eight scratch registers with distinct values and reads them back. Index confusion and the upper half of the window, group 0x020, would both show up there. Refused selector values are tried with a low bit, a bit just above the mask and the top bit, and each is followed by a selector read-back, so that a partial update cannot hide. Reads and writes to the status group (with both wide_mode levels), to group 0x3E0 and to group 0x040 are each followed by a full scratch read-back. This separates "ignored" from "written somewhere else". Same-cycle read/write, idle cycles and a reset in the middle of the run check the read timing and the clearing.

// File: rtl/isp_pkg.sv
package isp_pkg;

  // Result of decoding the stored selector for a data access
  typedef enum logic [1:0] {
    ACC_SCRATCH = 2'd0,
    ACC_STATUS  = 2'd1,
    ACC_UNIMPL  = 2'd2
  } acc_kind_t;

endpackage

// File: rtl/isp_addr_reg.sv
module isp_addr_reg #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 10,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 10'h3F8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              reject_o
);

  localparam logic [DATA_W-1:0] MASK_EXT = DATA_W'(ADDR_MASK);

  logic [ADDR_W-1:0] addr_q;

  assign reject_o = (wdata_i & ~MASK_EXT) != '0;
  assign addr_o   = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (wr_i && !reject_o) begin
      addr_q <= wdata_i[ADDR_W-1:0];
    end
  end

  // R2
  addr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && reject_o) |=> $stable(addr_q));

  // R1
  addr_legal_chk: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> ((addr_q & ~ADDR_MASK) == '0));

endmodule

// File: rtl/isp_decode.sv
module isp_decode
  import isp_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned IDX_LSB = 3,
  parameter int unsigned IDX_W = 3,
  parameter logic [ADDR_W-1:0] GROUP_MASK = 10'h3E0,
  parameter logic [ADDR_W-1:0] STATUS_GROUP = 10'h1E0,
  parameter bit FULL_WINDOW = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_t         kind_o,
  output logic [IDX_W-1:0]  idx_o
);

  // Top index bit overlaps the group field; the full window ignores it
  localparam logic [ADDR_W-1:0] HALF_BIT = ADDR_W'(1) << (IDX_LSB + IDX_W - 1);

  logic win;
  logic status_hit;

  generate
    if (FULL_WINDOW) begin : g_full
      assign win = (addr_i & GROUP_MASK & ~HALF_BIT) == '0;
    end else begin : g_half
      assign win = (addr_i & GROUP_MASK) == '0;
    end
  endgenerate

  assign status_hit = (addr_i & GROUP_MASK) == STATUS_GROUP;
  assign idx_o      = addr_i[IDX_LSB +: IDX_W];

  always_comb begin
    if (win) begin
      kind_o = ACC_SCRATCH;
    end else if (status_hit) begin
      kind_o = ACC_STATUS;
    end else begin
      kind_o = ACC_UNIMPL;
    end
  end

endmodule

// File: rtl/isp_scratch_bank.sv
module isp_scratch_bank #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned N_REGS = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [N_REGS-1:0][DATA_W-1:0] mem_q;

  generate
    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          mem_q[g] <= '0;
        end else if (we_i && (idx_i == IDX_W'(g))) begin
          mem_q[g] <= wdata_i;
        end
      end
    end
  endgenerate

  assign rdata_o = mem_q[idx_i];

  // R6
  bank_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(mem_q));

  // R3
  bank_store_chk: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (mem_q[$past(idx_i)] == $past(wdata_i)));

endmodule

// File: rtl/isp_port.sv
module isp_port
  import isp_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned N_SCRATCH = 8,
  parameter int unsigned IDX_LSB = 3,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 10'h3F8,
  parameter logic [ADDR_W-1:0] GROUP_MASK = 10'h3E0,
  parameter logic [ADDR_W-1:0] STATUS_GROUP = 10'h1E0,
  parameter bit FULL_WINDOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_data,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wide_mode,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);

  localparam int unsigned IDX_W = $clog2(N_SCRATCH);
  localparam logic [DATA_W-1:0] STATUS_WORD = {1'b1, {(DATA_W-1){1'b0}}};

  logic              addr_wr, addr_rd, data_wr, data_rd;
  logic [ADDR_W-1:0] addr;
  logic              reject;
  acc_kind_t         kind;
  logic [IDX_W-1:0]  idx;
  logic              scr_we;
  logic [DATA_W-1:0] scr_rdata;
  logic [DATA_W-1:0] rd_next;
  logic              err_next;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;

  assign addr_wr = wr_en && !sel_data;
  assign addr_rd = rd_en && !sel_data;
  assign data_wr = wr_en && sel_data;
  assign data_rd = rd_en && sel_data;

  isp_addr_reg #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .ADDR_MASK(ADDR_MASK)
  ) i_addr (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (addr_wr),
    .wdata_i (wdata),
    .addr_o  (addr),
    .reject_o(reject)
  );

  isp_decode #(
    .ADDR_W      (ADDR_W),
    .IDX_LSB     (IDX_LSB),
    .IDX_W       (IDX_W),
    .GROUP_MASK  (GROUP_MASK),
    .STATUS_GROUP(STATUS_GROUP),
    .FULL_WINDOW (FULL_WINDOW)
  ) i_dec (
    .addr_i(addr),
    .kind_o(kind),
    .idx_o (idx)
  );

  assign scr_we = data_wr && (kind == ACC_SCRATCH);

  isp_scratch_bank #(
    .DATA_W(DATA_W),
    .N_REGS(N_SCRATCH),
    .IDX_W (IDX_W)
  ) i_bank (
    .clk    (clk),
    .rst    (rst),
    .we_i   (scr_we),
    .idx_i  (idx),
    .wdata_i(wdata),
    .rdata_o(scr_rdata)
  );

  always_comb begin
    rd_next = '0;
    if (addr_rd) begin
      rd_next = DATA_W'(addr);
    end else begin
      case (kind)
        ACC_SCRATCH: rd_next = scr_rdata;
        ACC_STATUS:  rd_next = wide_mode ? STATUS_WORD : '0;
        default:     rd_next = '0;
      endcase
    end
  end

  assign err_next = (addr_wr && reject)
                 || (data_wr && (kind != ACC_SCRATCH))
                 || (data_rd && (kind == ACC_UNIMPL));

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (rd_en) begin
        rdata_q <= rd_next;
      end
      err_q <= err_next;
    end
  end

  assign rdata = rdata_q;
  assign err   = err_q;

  // R7
  err_origin_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(rd_en || wr_en));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R4
  status_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (data_rd && (kind == ACC_STATUS)) |=> (rdata[DATA_W-2:0] == '0));

  // R5
  unimpl_read_chk: assert property (@(posedge clk) disable iff (rst)
    (data_rd && (kind == ACC_UNIMPL)) |=> (err && (rdata == '0)));

endmodule

// File: tb/test_isp_port.sv
`timescale 1ns/1ps
module test_isp_port;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_data = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wdata = '0;
  logic        wide_mode = 1'b0;
  logic [63:0] rdata;
  logic        err;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // reference state
  logic [63:0] m_scr [8];
  logic [63:0] m_addr = '0;
  logic [63:0] m_rdata = '0;
  logic        m_err = 1'b0;

  always #2.5 clk = ~clk;

  isp_port i_isp_port (
    .clk      (clk),
    .rst      (rst),
    .sel_data (sel_data),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .wide_mode(wide_mode),
    .rdata    (rdata),
    .err      (err)
  );

  function automatic bit in_window(input logic [63:0] a);
    return a < 64'h40;
  endfunction

  task automatic model_step();
    logic [63:0] nrd;
    logic        nerr;
    int          ix;
    nrd  = m_rdata;
    nerr = 1'b0;
    ix   = int'((m_addr >> 3) % 8);
    if (rst) begin
      foreach (m_scr[k]) m_scr[k] = '0;
      m_addr = '0; nrd = '0;
    end else begin
      if (rd_en) begin
        if (!sel_data) nrd = m_addr;
        else if (in_window(m_addr)) nrd = m_scr[ix];
        else if ((m_addr & 64'h3E0) == 64'h1E0) nrd = wide_mode ? (64'd1 << 63) : 64'd0;
        else begin nrd = '0; nerr = 1'b1; end
      end
      if (wr_en) begin
        if (!sel_data) begin
          if ((wdata & ~64'h3F8) != 0) nerr = 1'b1;
          else m_addr = wdata;
        end else if (in_window(m_addr)) m_scr[ix] = wdata;
        else nerr = 1'b1;
      end
    end
    m_rdata = nrd;
    m_err   = nerr;
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic r, input logic s, input logic rd, input logic wr,
                      input logic [63:0] d, input logic wm, input string tag);
    rst = r; sel_data = s; rd_en = rd; wr_en = wr; wdata = d; wide_mode = wm;
    @(posedge clk);
    model_step();
    @(negedge clk);
    vectors++;
    if (rdata !== m_rdata || err !== m_err) begin
      miscompares++;
      $display("FAIL %s: rdata=%h err=%b, expected rdata=%h err=%b",
               tag, rdata, err, m_rdata, m_err);
    end
  endtask

  task automatic set_addr(input logic [63:0] a, input string tag);
    step(0, 0, 0, 1, a, 0, tag);
  endtask
  task automatic rd_addr(input string tag);
    step(0, 0, 1, 0, '0, 0, tag);
  endtask
  task automatic wr_data(input logic [63:0] d, input string tag);
    step(0, 1, 0, 1, d, 0, tag);
  endtask
  task automatic rd_data(input logic wm, input string tag);
    step(0, 1, 1, 0, '0, wm, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 0, 0, 0, '0, 0, tag);
  endtask
  task automatic scan_all(input string tag);
    for (int i = 0; i < 8; i++) begin
      set_addr(64'(i) << 3, tag);
      rd_data(0, tag);
    end
  endtask

  initial begin
    foreach (m_scr[k]) m_scr[k] = '0;
    @(negedge clk);
    // R8: reset state
    step(1, 0, 0, 0, '0, 0, "R8");
    step(1, 0, 0, 0, '0, 0, "R8");
    rd_addr("R8");
    rd_data(0, "R8");

    // R1, R3: fill every scratch register, then read back
    for (int i = 0; i < 8; i++) begin
      set_addr(64'(i) << 3, "R1");
      rd_addr("R1");
      wr_data(64'hA5A5_0000_0000_0000 ^ (64'(i + 1) * 64'h0101_0303_0707_1111), "R3");
    end
    scan_all("R3");

    // R2: refused selector values leave the selector alone
    set_addr(64'h018, "R1");
    set_addr(64'h004, "R2");
    rd_addr("R2");
    set_addr(64'h400, "R2");
    rd_addr("R2");
    set_addr(64'h8000_0000_0000_0000, "R2");
    rd_addr("R2");
    idle("R7");
    rd_data(0, "R2");

    // R4: status group with both mode levels
    set_addr(64'h1E0, "R1");
    rd_data(1, "R4");
    rd_data(0, "R4");
    set_addr(64'h1F8, "R4");
    rd_data(1, "R4");

    // R6: status write is dropped
    wr_data(64'hFFFF_FFFF_FFFF_FFFF, "R6");
    idle("R7");
    scan_all("R6");

    // R5, R6: other unimplemented groups
    set_addr(64'h3F8, "R5");
    rd_data(1, "R5");
    wr_data(64'h1234, "R6");
    set_addr(64'h040, "R5");
    rd_data(0, "R5");
    wr_data(64'h5678, "R6");
    set_addr(64'h200, "R5");
    rd_data(0, "R5");
    scan_all("R6");

    // R9: same-cycle read and write, then hold
    set_addr(64'h028, "R9");
    step(0, 1, 1, 1, 64'hDEAD_BEEF_CAFE_F00D, 0, "R9");
    idle("R9");
    idle("R9");
    rd_data(0, "R9");
    idle("R9");

    // R7: back-to-back offending strobes
    set_addr(64'h001, "R7");
    set_addr(64'h002, "R7");
    idle("R7");

    // R8: reset mid-run clears everything
    step(1, 0, 0, 0, '0, 0, "R8");
    rd_addr("R8");
    scan_all("R8");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule